// File: doc/BRIEF.md
# Byte-Wide Slave Configuration Port

This block is the receiving end of an 8-bit parallel configuration link driven by an external host. The host clocks the link and drives an active-low select (`cs_n`), an active-low write strobe (`wr_n`) and a data byte. The block answers with a `busy` flow-control flag. A byte is taken on a rising clock edge only when the host has both strobes low and `busy` is low. While `busy` is high, the host keeps the byte on the bus until a later edge.

The incoming bytes go through a 32-bit window, most significant byte first. Until the window holds the synchronization word 0xAA995566, nothing is forwarded. Once that word is matched, every following group of four bytes is forwarded as one packet word to a downstream sink over a valid/ready handshake. The synchronization word itself is not forwarded.

The host may release `cs_n` between bytes and resume later without losing word alignment. Holding `cs_n` low while `wr_n` is high aborts the transfer. The block then raises `busy` for a fixed cleanup period, discards any partly assembled word and its alignment, and looks for a new synchronization word.

Top module: `cfg_byte_port`

## Requirements
- R1: A byte on `din` is taken on a rising edge only when `cs_n`=0, `wr_n`=0 and `busy`=0 just before that edge. A byte offered while `busy`=1 is not taken, and the same byte is taken at the first later edge with `busy`=0.
- R2: While `cs_n`=1, every edge is ignored whatever `wr_n` and `din` are. No byte is taken, no abort occurs and no word is produced.
- R3: Before alignment, bytes shift into a 32-bit window, most significant byte first. Alignment is gained on the byte that makes the window equal 0xAA995566, even when earlier bytes precede it. Neither the bytes before that point nor the synchronization word reach the sink.
- R4: After alignment, each group of four taken bytes forms one word with the first byte in bits 31:24. `word_valid` rises with that word on `word_data` in the cycle after the edge that took the fourth byte.
- R5: While `word_valid`=1 and `word_ready`=0, `word_data` stays unchanged and `busy`=1, so no further byte is taken. Words reach the sink in arrival order, with none lost.
- R6: An edge with `cs_n`=0 and `wr_n`=1, outside a cleanup period, is an abort. `busy` is then 1 for exactly the next 4 cycles and 0 afterwards, unless the sink is stalled.
- R7: After an abort, the partial word and the alignment are dropped. No word reaches the sink until a new synchronization word has been received.
- R8: Alignment and partial-word progress survive any number of `cs_n`=1 gaps between bytes, including gaps inside the synchronization word.
- R9: With `rst_n`=0 at an edge, alignment, the byte count and any pending word are cleared, so `busy`=0 and `word_valid`=0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock from the host, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| wr_n | input | 1 | Active-low write strobe from the host |
| din | input | 8 | Configuration data byte |
| busy | output | 1 | High when the byte on the bus will not be taken |
| word_data | output | 32 | Assembled packet word to the sink |
| word_valid | output | 1 | `word_data` holds a word not yet accepted |
| word_ready | input | 1 | Sink accepts the word at this edge |

## Verification
If the alignment state is wrong, it shows up at the sink. Either spurious words appear before the synchronization word, or expected words are missing or rotated by a byte. This is visible one cycle after the fourth byte of the affected group. A wrong cleanup counter shows directly as a `busy` pulse of the wrong length, counted cycle by cycle after the abort edge. A wrong hold-off shows as changed `word_data` under a stalled sink, or as a lost or duplicated word once the sink resumes.

// File: rtl/cfg_port_pkg.sv
// Package: shared constants and types for the byte-wide configuration port.
// Assumes one byte lane feeding a word that is an integer number of bytes wide.
package cfg_port_pkg;
    localparam int unsigned BYTE_W       = 8;
    localparam int unsigned CFG_WORD_W   = 32;
    localparam logic [31:0] SYNC_PATTERN = 32'hAA99_5566;

    // Alignment state of the byte assembler.
    typedef enum logic {
        ALN_HUNT   = 1'b0,
        ALN_LOCKED = 1'b1
    } align_state_t;
endpackage

// File: rtl/cfg_abort_ctl.sv
// Module: detects the abort gesture (select held, write released) and times
// the cleanup period that follows it.
// Assumes: inputs are already in the clk domain; a new abort is not
// recognised while a cleanup period is running.
module cfg_abort_ctl #(
    parameter int unsigned CLEANUP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    output logic abort_hit,
    output logic cleanup_busy
);
    localparam int unsigned CNT_W = $clog2(CLEANUP_CYCLES + 1);

    logic [CNT_W-1:0] cleanup_cnt;

    // Abort is seen on an edge with select low, write high, and no cleanup running.
    assign abort_hit    = !cs_n && wr_n && (cleanup_cnt == '0);
    assign cleanup_busy = (cleanup_cnt != '0);

    // Load the cleanup counter on an abort, then count it down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cleanup_cnt <= '0;
        end else if (abort_hit) begin
            cleanup_cnt <= CNT_W'(CLEANUP_CYCLES);
        end else if (cleanup_cnt != '0) begin
            cleanup_cnt <= cleanup_cnt - 1'b1;
        end
    end

    // R6: an abort is followed by a busy cleanup period.
    assert_busy_after_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
        abort_hit |=> cleanup_busy);

    // R6: the cleanup period ends after its final count without a new abort.
    assert_cleanup_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cleanup_cnt == CNT_W'(1)) |=> !cleanup_busy);
endmodule

// File: rtl/cfg_word_align.sv
// Module: shifts taken bytes into a word window, hunts for the sync pattern,
// and after lock emits every group of bytes as one word.
// Assumes: byte_take and flush are never high together; the consumer of
// word_done always has room (guaranteed by the busy hold-off upstream).
module cfg_word_align
    import cfg_port_pkg::*;
#(
    parameter int unsigned          DATA_W = BYTE_W,
    parameter int unsigned          WORD_W = CFG_WORD_W,
    parameter logic [WORD_W-1:0]    SYNC   = SYNC_PATTERN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_take,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              flush,
    output logic              word_done,
    output logic [WORD_W-1:0] word_out
);
    localparam int unsigned BYTES_PER_WORD = WORD_W / DATA_W;
    localparam int unsigned CNT_W          = (BYTES_PER_WORD > 1) ? $clog2(BYTES_PER_WORD) : 1;

    align_state_t      state;
    logic [WORD_W-1:0] window;
    logic [WORD_W-1:0] window_next;
    logic [CNT_W-1:0]  byte_cnt;
    logic              last_byte;

    // Next window contents: the new byte enters at the least significant end.
    assign window_next = {window[WORD_W-DATA_W-1:0], byte_in};
    assign last_byte   = (byte_cnt == CNT_W'(BYTES_PER_WORD - 1));
    assign word_done   = byte_take && (state == ALN_LOCKED) && last_byte;
    assign word_out    = window_next;

    // Track alignment and the byte position; flush and reset forget both.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            state    <= ALN_HUNT;
            window   <= '0;
            byte_cnt <= '0;
        end else if (byte_take) begin
            window <= window_next;
            if (state == ALN_HUNT) begin
                if (window_next == SYNC) begin
                    state    <= ALN_LOCKED;
                    byte_cnt <= '0;
                end
            end else begin
                byte_cnt <= last_byte ? '0 : byte_cnt + 1'b1;
            end
        end
    end

    // R7: a flush always leaves the assembler hunting with no partial word.
    assert_flush_unlocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (state == ALN_HUNT) && (byte_cnt == '0));

    // R3: lock is only gained on an edge that took a byte.
    assert_lock_on_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ALN_LOCKED) && ($past(state) == ALN_HUNT) |-> $past(byte_take));

    // R2: without a taken byte or a flush the window holds still.
    assert_window_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_take && !flush |=> $stable(window));
endmodule

// File: rtl/cfg_word_out.sv
// Module: single-entry holding register between the assembler and the sink,
// speaking valid/ready on the sink side.
// Assumes: load is only raised when the slot is empty or draining this edge.
module cfg_word_out #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_data,
    output logic [WORD_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready
);
    // Hold a word until the sink takes it; a new load replaces a drained word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_data  <= load_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // R5: a stalled word stays put and stays valid.
    assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R9: reset leaves no pending word.
    assert_reset_clears_R9: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
endmodule

// File: rtl/cfg_byte_port.sv
// Module: top of the byte-wide slave configuration port. Qualifies host
// strobes into byte takes, combines abort cleanup and sink stall into busy,
// and wires the assembler to the output register.
// Assumes: host strobes and data are synchronous to clk.
module cfg_byte_port
    import cfg_port_pkg::*;
#(
    parameter int unsigned DATA_W         = BYTE_W,
    parameter int unsigned WORD_W         = CFG_WORD_W,
    parameter int unsigned CLEANUP_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] din,
    output logic              busy,
    output logic [WORD_W-1:0] word_data,
    output logic              word_valid,
    input  logic              word_ready
);
    logic              abort_hit;
    logic              cleanup_busy;
    logic              byte_take;
    logic              word_done;
    logic [WORD_W-1:0] word_asm;

    // Busy while cleaning up after an abort or while the sink stalls a word.
    assign busy      = cleanup_busy || (word_valid && !word_ready);
    // A byte is taken only with both strobes low and no hold-off.
    assign byte_take = !cs_n && !wr_n && !busy;

    cfg_abort_ctl #(
        .CLEANUP_CYCLES(CLEANUP_CYCLES)
    ) u_abort (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n        (cs_n),
        .wr_n        (wr_n),
        .abort_hit   (abort_hit),
        .cleanup_busy(cleanup_busy)
    );

    cfg_word_align #(
        .DATA_W(DATA_W),
        .WORD_W(WORD_W),
        .SYNC  (WORD_W'(SYNC_PATTERN))
    ) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_take(byte_take),
        .byte_in  (din),
        .flush    (abort_hit),
        .word_done(word_done),
        .word_out (word_asm)
    );

    cfg_word_out #(
        .WORD_W(WORD_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (word_done),
        .load_data(word_asm),
        .out_data (word_data),
        .out_valid(word_valid),
        .out_ready(word_ready)
    );

    // R5: a finished word never lands on a stalled, occupied output slot.
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> (!word_valid || word_ready));

    // R1: every new word was preceded by a byte taken at the previous edge.
    assert_word_from_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && word_valid && !$past(word_valid) |-> $past(byte_take));
endmodule

// File: tb/cfg_byte_port_tb.sv
module cfg_byte_port_tb;
    localparam logic [31:0] SYNC = 32'hAA99_5566;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        wr_n = 1'b0;
    logic [7:0]  din = 8'h00;
    logic        busy;
    logic [31:0] word_data;
    logic        word_valid;
    logic        word_ready = 1'b1;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] got[$];

    always #5 clk = ~clk;

    cfg_byte_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .din       (din),
        .busy      (busy),
        .word_data (word_data),
        .word_valid(word_valid),
        .word_ready(word_ready)
    );

    // Sink model: record each word handed over at the coming edge.
    always begin
        @(negedge clk);
        #3;
        if (rst_n && word_valid && word_ready) got.push_back(word_data);
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cs_n = 1'b1;
            wr_n = i[0];
            din  = 8'(i * 37 + 5);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic bz;
        bz = 1'b1;
        while (bz) begin
            @(negedge clk);
            cs_n = 1'b0; wr_n = 1'b0; din = b;
            #1 bz = busy;
            @(posedge clk);
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int i = 3; i >= 0; i--) send_byte(w[i*8 +: 8]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b0; word_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        got.delete();
    endtask

    task automatic expect_got(input string req, input logic [31:0] e0, input logic [31:0] e1, input int n);
        check(got.size() == n, req, 32'(got.size()), 32'(n));
        if (n > 0 && got.size() > 0) check(got[0] == e0, req, got[0], e0);
        if (n > 1 && got.size() > 1) check(got[1] == e1, req, got[1], e1);
        got.delete();
    endtask

    // R9 reset state, plus reset mid-stream forgetting alignment.
    task automatic t_reset();
        do_reset();
        #1;
        check(busy == 1'b0, "R9", 32'(busy), 0);
        check(word_valid == 1'b0, "R9", 32'(word_valid), 0);
        send_word(SYNC);
        send_byte(8'h11); send_byte(8'h22);
        do_reset();
        #1;
        check(busy == 1'b0 && word_valid == 1'b0, "R9", 32'({busy, word_valid}), 0);
        send_byte(8'h33); send_byte(8'h44);
        send_word(32'hDEAD_BEEF);
        idle(4);
        expect_got("R9", 0, 0, 0);
    endtask

    // R3/R4: junk before sync dropped, sync not forwarded, MSB-first words, latency.
    task automatic t_sync_basic();
        do_reset();
        send_word(32'h1234_5678);
        send_byte(8'h0F);
        send_word(SYNC);
        idle(2);
        check(got.size() == 0, "R3", 32'(got.size()), 0);
        send_word(32'hC001_D00D);
        @(negedge clk);
        cs_n = 1'b1;
        #2;
        check(word_valid && word_data == 32'hC001_D00D, "R4", word_data, 32'hC001_D00D);
        send_word(32'h0102_0304);
        idle(3);
        expect_got("R4", 32'hC001_D00D, 32'h0102_0304, 2);
    endtask

    // R2/R8: gaps with cs_n high, wr_n toggling, inside a word and inside sync.
    task automatic t_gaps();
        do_reset();
        send_byte(8'hAA); send_byte(8'hAA); send_byte(8'h99);
        idle(3);
        send_byte(8'h55);
        idle(2);
        send_byte(8'h66);
        send_byte(8'hFE);
        idle(5);
        check(word_valid == 1'b0 && busy == 1'b0, "R2", 32'({word_valid, busy}), 0);
        send_byte(8'hED);
        idle(1);
        send_byte(8'hFA); send_byte(8'hCE);
        idle(3);
        expect_got("R8", 32'hFEED_FACE, 0, 1);
    endtask

    // R5/R1: stalled sink holds the word and blocks the next byte.
    task automatic t_backpressure();
        do_reset();
        send_word(SYNC);
        word_ready = 1'b0;
        send_word(32'hA1B2_C3D4);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; din = 8'h5A;
        for (int i = 0; i < 3; i++) begin
            #1;
            check(busy == 1'b1, "R5", 32'(busy), 1);
            check(word_valid && word_data == 32'hA1B2_C3D4, "R5", word_data, 32'hA1B2_C3D4);
            @(negedge clk);
        end
        word_ready = 1'b1;
        @(posedge clk);
        send_byte(8'h6B); send_byte(8'h7C); send_byte(8'h8D);
        idle(3);
        expect_got("R1", 32'hA1B2_C3D4, 32'h5A6B_7C8D, 2);
    endtask

    // R6/R7: abort mid-word, cleanup length, then no words until a new sync.
    task automatic t_abort();
        do_reset();
        send_word(SYNC);
        send_byte(8'h01); send_byte(8'h02);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            #1;
            check(busy == 1'b1, "R6", 32'(i), 4);
            @(negedge clk);
        end
        #1;
        check(busy == 1'b0, "R6", 32'(busy), 0);
        send_byte(8'h03); send_byte(8'h04);
        send_word(32'h5555_6666);
        idle(3);
        expect_got("R7", 0, 0, 0);
        send_word(SYNC);
        send_word(32'h7777_8888);
        idle(3);
        expect_got("R7", 32'h7777_8888, 0, 1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_sync_basic();
                t_gaps();
                t_backpressure();
                t_abort();
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule